// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block owns the two special result registers, HIGH and LOW, and computes 32x32 products and 32/32 quotients one bit per clock. A request is a one-cycle `start_i` pulse carrying a 6-bit function code and two 32-bit operands. Long operations raise `busy_o` for their whole run and finish with a one-cycle `done_o` pulse, at which point HIGH and LOW hold the result. A product is split with its upper half in HIGH and its lower half in LOW. A division leaves the quotient in LOW and the remainder in HIGH.

Two register moves load HIGH or LOW straight from `op_a_i` in a single cycle. Two register reads return HIGH or LOW on `rd_data_o`, selected by `func_i` alone. Only one long operation runs at a time. A request that arrives while the unit is busy is dropped. No overflow is reported. Division by zero gives no defined value, but it still completes on schedule.

Top module: `mdu_core`

## Requirements
- R1: Function 011000 (signed product) treats both operands as two's complement. The 64-bit result goes to HIGH (bits 63:32) and LOW (bits 31:0), and it is negative when the operand signs differ.
- R2: Function 011001 (unsigned product) treats both operands as unsigned and places the 64-bit result in HIGH:LOW.
- R3: Function 011010 (signed division) writes the quotient, truncated toward zero, to LOW and the remainder to HIGH. The quotient is negative when the operand signs differ, and the remainder carries the sign of the dividend. The case 0x80000000 / -1 yields a quotient of 0x80000000 and a remainder of 0.
- R4: Function 011011 (unsigned division) writes the unsigned quotient to LOW and the unsigned remainder to HIGH.
- R5: For a product accepted at clock edge k, `done_o` is high and HIGH/LOW hold the result after edge k+32, and not before.
- R6: For a division accepted at clock edge k, `done_o` is high and HIGH/LOW hold the result after edge k+38, and not before.
- R7: `busy_o` goes high after the accepting edge and stays high until the edge that raises `done_o`, where it falls. `done_o` is a single-cycle pulse.
- R8: A `start_i` while `busy_o` is high is ignored, whatever its function. This includes register moves and new long operations: the running result and its timing are unchanged.
- R9: Function 010001 loads HIGH from `op_a_i`, and 010011 loads LOW from `op_a_i`. Either takes effect after the accepting edge, without raising `busy_o` or `done_o`.
- R10: `rd_data_o` shows HIGH when `func_i` is 010000 and LOW when it is 010010, combinationally. For any other code it shows zero.
- R11: A division with a zero divisor still completes with the R6 timing and returns the unit to idle.
- R12: After reset, HIGH, LOW, `busy_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, qualified by func_i |
| func_i | input | 6 | Function code |
| op_a_i | input | 32 | First operand (dividend, multiplicand, move source) |
| op_b_i | input | 32 | Second operand (divisor, multiplier) |
| busy_o | output | 1 | Long operation in progress |
| done_o | output | 1 | One-cycle pulse: result written to HIGH/LOW |
| hi_o | output | 32 | Current HIGH register |
| lo_o | output | 32 | Current LOW register |
| rd_data_o | output | 32 | Register read result selected by func_i |

## Verification
Products are due 32 edges after the accepting edge and divisions 38 edges after it. Moves take effect after the accepting edge itself, and reads are combinational within the same cycle. The bench holds a behavioural model that counts down the same number of edges from the request and updates its expected HIGH, LOW, busy and done at the matching edge. Every cycle, the outputs are compared against this model a few nanoseconds after the falling edge. An early or late result, a stretched done pulse, or a request that leaks through while busy therefore shows up in the exact cycle it goes wrong.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [5:0] FN_MFHI  = 6'b010000;
  localparam logic [5:0] FN_MTHI  = 6'b010001;
  localparam logic [5:0] FN_MFLO  = 6'b010010;
  localparam logic [5:0] FN_MTLO  = 6'b010011;
  localparam logic [5:0] FN_MULT  = 6'b011000;
  localparam logic [5:0] FN_MULTU = 6'b011001;
  localparam logic [5:0] FN_DIV   = 6'b011010;
  localparam logic [5:0] FN_DIVU  = 6'b011011;

  function automatic logic fn_is_long(input logic [5:0] f);
    return (f == FN_MULT) || (f == FN_MULTU) || (f == FN_DIV) || (f == FN_DIVU);
  endfunction

  function automatic logic fn_is_div(input logic [5:0] f);
    return (f == FN_DIV) || (f == FN_DIVU);
  endfunction

  function automatic logic fn_is_signed(input logic [5:0] f);
    return (f == FN_MULT) || (f == FN_DIV);
  endfunction
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl #(
  parameter int unsigned MUL_LAT = 32,
  parameter int unsigned DIV_LAT = 38,
  parameter int unsigned CW      = $clog2(DIV_LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          is_div_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          is_div_o,
  output logic [CW-1:0] step_o,
  output logic          finish_o
);
  localparam logic [CW-1:0] MUL_LAST = CW'(MUL_LAT - 1);
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_LAT - 1);

  logic          busy_q, done_q, is_div_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last     = is_div_q ? DIV_LAST : MUL_LAST;
  assign finish_o = busy_q && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      is_div_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      done_q <= finish_o;
      if (launch_i) begin
        busy_q   <= 1'b1;
        cnt_q    <= '0;
        is_div_q <= is_div_i;
      end else if (busy_q) begin
        if (finish_o) busy_q <= 1'b0;
        else          cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign is_div_o = is_div_q;
  assign step_o   = cnt_q;

  assert_busy_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !finish_o |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1));
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_ends_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_count_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= last);
endmodule

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int unsigned W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           step_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] prod_q, prod_nx;
  logic [W-1:0]   mcand_q, a_mag, b_mag;
  logic           neg_q;
  logic [W:0]     upper;

  assign a_mag = (signed_i && a_i[W-1]) ? -a_i : a_i;
  assign b_mag = (signed_i && b_i[W-1]) ? -b_i : b_i;

  // shift-add: add multiplicand into upper half when lsb set, then shift right
  assign upper   = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
  assign prod_nx = step_i ? {upper, prod_q[W-1:1]} : prod_q;
  assign prod_o  = neg_q ? -prod_nx : prod_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      mcand_q <= '0;
      neg_q   <= 1'b0;
    end else if (load_i) begin
      prod_q  <= {{W{1'b0}}, b_mag};
      mcand_q <= a_mag;
      neg_q   <= signed_i && (a_i[W-1] ^ b_i[W-1]);
    end else begin
      prod_q <= prod_nx;
    end
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         step_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, quo_q, dvs_q, a_mag, b_mag;
  logic [W-1:0] rem_nx, quo_nx;
  logic         qneg_q, rneg_q, fits;
  logic [W:0]   shifted, diff;

  assign a_mag = (signed_i && a_i[W-1]) ? -a_i : a_i;
  assign b_mag = (signed_i && b_i[W-1]) ? -b_i : b_i;

  // restoring step: bring in next dividend bit, subtract divisor if it fits
  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign fits    = shifted >= {1'b0, dvs_q};
  assign rem_nx  = !step_i ? rem_q : (fits ? diff[W-1:0] : shifted[W-1:0]);
  assign quo_nx  = !step_i ? quo_q : {quo_q[W-2:0], fits};

  assign quo_o = qneg_q ? -quo_nx : quo_nx;
  assign rem_o = rneg_q ? -rem_nx : rem_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
    end else if (load_i) begin
      rem_q  <= '0;
      quo_q  <= a_mag;
      dvs_q  <= b_mag;
      qneg_q <= signed_i && (a_i[W-1] ^ b_i[W-1]);
      rneg_q <= signed_i && a_i[W-1];
    end else begin
      rem_q <= rem_nx;
      quo_q <= quo_nx;
    end
  end

  assert_partial_rem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter int unsigned MUL_LAT = 32,
  parameter int unsigned DIV_LAT = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [5:0]   func_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] rd_data_o
);
  localparam int unsigned MAX_LAT = (DIV_LAT > MUL_LAT) ? DIV_LAT : MUL_LAT;
  localparam int unsigned CW      = $clog2(MAX_LAT + 1);

  logic           busy, is_div, finish, accept, launch, step_en;
  logic [CW-1:0]  step;
  logic [W-1:0]   hi_q, lo_q, quo, rem;
  logic [2*W-1:0] prod;

  assign accept  = start_i && !busy;
  assign launch  = accept && fn_is_long(func_i);
  assign step_en = busy && (step < CW'(W));

  mdu_ctrl #(.MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .CW(CW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .is_div_i(fn_is_div(func_i)),
    .busy_o(busy), .done_o(done_o), .is_div_o(is_div), .step_o(step), .finish_o(finish)
  );

  mdu_mul #(.W(W)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(launch && !fn_is_div(func_i)),
    .signed_i(fn_is_signed(func_i)), .a_i(op_a_i), .b_i(op_b_i),
    .step_i(step_en && !is_div), .prod_o(prod)
  );

  mdu_div #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(launch && fn_is_div(func_i)),
    .signed_i(fn_is_signed(func_i)), .a_i(op_a_i), .b_i(op_b_i),
    .step_i(step_en && is_div), .quo_o(quo), .rem_o(rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (finish) begin
      hi_q <= is_div ? rem : prod[2*W-1:W];
      lo_q <= is_div ? quo : prod[W-1:0];
    end else if (accept && func_i == FN_MTHI) begin
      hi_q <= op_a_i;
    end else if (accept && func_i == FN_MTLO) begin
      lo_q <= op_a_i;
    end
  end

  always_comb begin
    unique case (func_i)
      FN_MFHI: rd_data_o = hi_q;
      FN_MFLO: rd_data_o = lo_q;
      default: rd_data_o = '0;
    endcase
  end

  assign busy_o = busy;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  assert_busy_ignores_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !finish |=> $stable(hi_q) && $stable(lo_q));
  assert_move_no_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && start_i && (func_i == FN_MTHI || func_i == FN_MTLO) |=> !busy && !done_o);
  assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy));
endmodule

// File: tb/mdu_core_bench.sv
module mdu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  func = 6'b111111;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] hi, lo, rd;

  always #4 clk = ~clk;

  mdu_core u_mdu_core (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .op_a_i(op_a), .op_b_i(op_b), .busy_o(busy), .done_o(done),
    .hi_o(hi), .lo_o(lo), .rd_data_o(rd)
  );

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R12";
  bit finished = 0;

  // behavioural model
  int          m_cnt = 0;
  bit          m_busy = 0, m_done = 0, m_xh = 0, m_xl = 0, p_x = 0;
  logic [31:0] m_hi = '0, m_lo = '0, p_hi, p_lo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_busy = 0; m_done = 0; m_hi = '0; m_lo = '0; m_xh = 0; m_xl = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_hi = p_hi; m_lo = p_lo; m_xh = p_x; m_xl = p_x;
        end
      end else if (start) begin
        longint sa, sb, ua, ub, q, r;
        logic [63:0] p;
        sa = longint'($signed(op_a)); sb = longint'($signed(op_b));
        ua = longint'({32'd0, op_a}); ub = longint'({32'd0, op_b});
        p_x = 0;
        case (func)
          6'b011000: begin p = 64'(sa * sb); p_hi = p[63:32]; p_lo = p[31:0]; m_cnt = 32; end
          6'b011001: begin p = 64'(ua * ub); p_hi = p[63:32]; p_lo = p[31:0]; m_cnt = 32; end
          6'b011010, 6'b011011: begin
            m_cnt = 38;
            if (op_b == 0) begin p_x = 1; p_hi = '0; p_lo = '0; end
            else begin
              if (func == 6'b011010) begin q = sa / sb; r = sa % sb; end
              else begin q = ua / ub; r = ua % ub; end
              p_lo = q[31:0]; p_hi = r[31:0];
            end
          end
          6'b010001: begin m_hi = op_a; m_xh = 0; end
          6'b010011: begin m_lo = op_a; m_xl = 0; end
          default: ;
        endcase
        if (m_cnt > 0) m_busy = 1;
      end
    end
  end

  // compare every cycle, away from both edges
  always begin
    @(negedge clk); #3;
    if (!finished) begin
      logic [31:0] e_rd;
      bit bad;
      e_rd = (func == 6'b010000) ? m_hi : (func == 6'b010010) ? m_lo : '0;
      bad = (busy !== m_busy) || (done !== m_done);
      if (!m_xh) bad |= (hi !== m_hi);
      if (!m_xl) bad |= (lo !== m_lo);
      if (!((func == 6'b010000 && m_xh) || (func == 6'b010010 && m_xl))) bad |= (rd !== e_rd);
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s: busy=%0b done=%0b hi=%h lo=%h rd=%h expected busy=%0b done=%0b hi=%h lo=%h rd=%h",
                 tag, busy, done, hi, lo, rd, m_busy, m_done, m_hi, m_lo, e_rd);
      end
    end
  end

  task automatic issue(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    func = f; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; func = 6'b111111;
  endtask

  task automatic settle();
    while (m_cnt > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input string t, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    tag = t;
    issue(f, a, b);
    settle();
  endtask

  task automatic report();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      report();
    end
  end

  initial begin
    tag = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 moves, R10 reads
    run("R9", 6'b010001, 32'hCAFE_0001, 32'h0);
    run("R9", 6'b010011, 32'h1234_5678, 32'h0);
    tag = "R10";
    @(negedge clk); func = 6'b010000;
    @(negedge clk); func = 6'b010010;
    @(negedge clk); func = 6'b011000;
    @(negedge clk); func = 6'b111111;
    // R1 / R5 signed products
    run("R1", 6'b011000, 32'd12345, -32'sd678);
    run("R1", 6'b011000, -32'sd7, -32'sd9);
    run("R5", 6'b011000, 32'h8000_0000, 32'h8000_0000);
    run("R1", 6'b011000, 32'h7FFF_FFFF, 32'h8000_0000);
    // R2 unsigned products
    run("R2", 6'b011001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R2", 6'b011001, 32'h8000_0000, 32'd3);
    // R3 / R6 signed division
    run("R3", 6'b011010, 32'd7, -32'sd2);
    run("R3", 6'b011010, -32'sd7, 32'd2);
    run("R6", 6'b011010, -32'sd7, -32'sd2);
    run("R3", 6'b011010, 32'h8000_0000, 32'hFFFF_FFFF);
    // R4 unsigned division
    run("R4", 6'b011011, 32'hFFFF_FFFE, 32'd7);
    run("R4", 6'b011011, 32'd5, 32'hFFFF_FFF0);
    // R11 divide by zero
    run("R11", 6'b011010, 32'd99, 32'd0);
    run("R11", 6'b011011, 32'hFFFF_FFFF, 32'd0);
    run("R9", 6'b010001, 32'h0000_00AA, 32'h0);
    run("R9", 6'b010011, 32'h0000_00BB, 32'h0);
    // R8 requests during busy are dropped
    tag = "R8";
    issue(6'b011001, 32'd1000, 32'd1000);
    repeat (5) @(negedge clk);
    issue(6'b010001, 32'hDEAD_BEEF, 32'h0);
    issue(6'b011010, 32'd50, 32'd5);
    issue(6'b010011, 32'hFEED_F00D, 32'h0);
    settle();
    // R7 back-to-back long operations
    tag = "R7";
    issue(6'b011010, 32'd100, 32'd9);
    while (m_cnt > 0) @(negedge clk);
    issue(6'b011000, -32'sd3, 32'd5);
    settle();
    report();
  end
endmodule